// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, day of week, day of month, month, and a year split into a century byte and a year-within-century byte. An external reference strobe `ref_tick` is divided by `PRE_DIV` to step a 7-bit sub-second counter at 128 Hz. Each wrap of that counter produces one seconds step, which ripples through the time and date fields. Day-of-month wrap follows the month length, with Gregorian leap years.

Software reaches every field through a small register bus. Writes take effect on the clock edge. Reads are combinational from `bus_addr`. A write of `bus_wide`=1 carries 16 bits; a write of `bus_wide`=0 carries 8 bits. Software reads the fields one at a time. A sticky carry flag tells it that a seconds step happened during the read sequence, so it can clear the flag and read again. A run-control state machine has three states:
- **OFF**: the counter is not valid and does not count.
- **HALT**: the counter is valid but frozen, so fields can be loaded.
- **RUN**: the counter is counting.

Each write to the run-control register moves the state machine:
- enable bit 0 leads to OFF;
- enable bit 1 with run bit 0 leads to HALT;
- enable bit 1 with run bit 1 leads to RUN.

These transitions apply from any state. With no such write, the state holds. The same register has a self-clearing bit that zeroes the prescaler and the sub-second counter.

Register addresses:

| Address | Register |
|---|---|
| 0 | sub-second (read only) |
| 1 | sec |
| 2 | min |
| 3 | hour |
| 4 | weekday |
| 5 | day of month |
| 6 | month |
| 7 | year |
| 8 | status |
| 9 | run-control |

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the fields read as follows, and `carry_irq` is 0:

  | Field | Reset value |
  |---|---|
  | sec, min, hour, weekday | 0x00 |
  | day, month | 0x01 |
  | year | 0x2000 |
  | status | 0 |
  | run-control | 0 (state OFF) |

- R2: In RUN, every `PRE_DIV` cycles with `ref_tick` high advance the sub-second counter (address 0) by one, modulo 128.
- R3: The seconds field advances exactly when the sub-second counter wraps from 127 to 0. With the default `PRE_DIV`=2, this is the 256th tick after a prescaler clear.
- R4: Rollovers of the time fields:
  - Seconds and minutes roll from 0x59 to 0x00 and carry into the next field.
  - Hours roll from 0x23 to 0x00 and produce a day step.
- R5: On a day step, the weekday advances and wraps from 6 to 0.
- R6: On a day step, the day of month wraps to 01 after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. Month wraps from 0x12 to 0x01 and carries into the year.
- R7: February ends on day 29 when the year within the century is divisible by 4 and nonzero, or when it is 00 and the century is divisible by 4. Otherwise February ends on day 28.
- R8: The year-within-century byte rolls from 0x99 to 0x00 and increments the century byte. The century byte rolls from 0x99 to 0x00.
- R9: Status bit 0 (carry flag) sets on every seconds step and stays set:
  - Writing status with bit 0 = 0 clears it.
  - Writing bit 0 = 1 has no effect on it.
  - If a seconds step and a clearing write occur in the same cycle, the step wins.
- R10: Status bit 1 is the carry interrupt enable. `carry_irq` is high exactly when bit 0 and bit 1 are both set.
- R11: Run-control bit 2 is enable and bit 0 is run. Writes to these bits select OFF, HALT or RUN as listed above. In OFF and HALT, neither the sub-second counter nor any field changes. A readback returns bit 2 = (state is not OFF) and bit 0 = (state is RUN).
- R12: Writing run-control with bit 1 = 1 clears the prescaler and the sub-second counter. Bit 1 reads back as 0.
- R13: A write to any field loads it, in any state.
  - A 16-bit write to address 7 loads both year bytes.
  - An 8-bit write to address 7 loads only the year-within-century byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference strobe, one per prescaler step |
| bus_we | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, zero-extended |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench drives the counter into each calendar boundary and expects a single seconds step to land on the next valid date:
- 30-day and 31-day month ends, where a wrong month-length decode skips a day or produces day 31 of April.
- February in a plain leap year, a common year, a 00 year of a leap century and a 00 year of a non-leap century, where a simplified divisible-by-4 rule produces 2100-02-29.
- Year and century wraps, where a lost carry leaves 2099 followed by 2000.

The bench also targets the 255th and 256th ticks, where an off-by-one prescaler steps the seconds early or late. It checks that a frozen counter stays still when ticks arrive, and that writing 1 to the carry flag leaves it set instead of toggling or clearing it.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_HALT, ST_RUN} run_state_e;

    localparam int unsigned ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_SUB  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HOUR = 4'd3;
    localparam logic [ADDR_W-1:0] A_WDAY = 4'd4;
    localparam logic [ADDR_W-1:0] A_MDAY = 4'd5;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
    localparam logic [ADDR_W-1:0] A_YEAR = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd9;

    // Two-digit BCD increment without range limit
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // (10t+u) mod 4 equals (2*(t mod 2) + u) mod 4
    function automatic logic bcd_div4(input logic [7:0] v);
        logic [1:0] s;
        s = {v[4], 1'b0} + v[1:0];
        return s == 2'd0;
    endfunction

    function automatic logic leap_year(input logic [7:0] cent, input logic [7:0] yy);
        return bcd_div4(yy) && ((yy != 8'h00) || bcd_div4(cent));
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int unsigned PRE_DIV = 2,
    parameter int unsigned SUB_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             ref_tick,
    output logic [SUB_W-1:0] sub,
    output logic             sec_tick
);
    localparam int unsigned PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0]    pre_q;
    logic [SUB_W-1:0] sub_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (run && ref_tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                sub_q <= sub_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign sub      = sub_q;
    assign sec_tick = run && ref_tick && !clr && (pre_q == PRE_LAST) && (&sub_q);

    // R2: sub-second only ever steps by one, except on a clear
    a_r2_sub_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q != $past(sub_q)) && !$past(clr) |-> (sub_q - $past(sub_q)) == SUB_W'(1));
endmodule

// File: rtl/cal_hms.sv
module cal_hms (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_sec,
    input  logic       wr_min,
    input  logic       wr_hour,
    input  logic [7:0] wdata,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic       day_tick
);
    import cal_pkg::*;

    logic [7:0] sec_q, min_q, hour_q;
    logic       sec_wrap, min_wrap, hour_wrap;

    assign sec_wrap  = sec_q  == 8'h59;
    assign min_wrap  = min_q  == 8'h59;
    assign hour_wrap = hour_q == 8'h23;
    assign day_tick  = tick && sec_wrap && min_wrap && hour_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h00;
        end else begin
            if (wr_sec)
                sec_q <= wdata;
            else if (tick)
                sec_q <= sec_wrap ? 8'h00 : bcd_next(sec_q);

            if (wr_min)
                min_q <= wdata;
            else if (tick && sec_wrap)
                min_q <= min_wrap ? 8'h00 : bcd_next(min_q);

            if (wr_hour)
                hour_q <= wdata;
            else if (tick && sec_wrap && min_wrap)
                hour_q <= hour_wrap ? 8'h00 : bcd_next(hour_q);
        end
    end

    assign sec  = sec_q;
    assign min  = min_q;
    assign hour = hour_q;

    // R4: seconds roll from 59 to 00
    a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !wr_sec && sec_q == 8'h59) |-> sec_q == 8'h00);
    // R4: hours roll from 23 to 00 on the last second of the day
    a_r4_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(day_tick && !wr_hour) |-> hour_q == 8'h00);
endmodule

// File: rtl/cal_date.sv
module cal_date (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_wday,
    input  logic        wr_mday,
    input  logic        wr_mon,
    input  logic        wr_yr_lo,
    input  logic        wr_yr_hi,
    input  logic [15:0] wdata,
    output logic [7:0]  wday,
    output logic [7:0]  mday,
    output logic [7:0]  mon,
    output logic [15:0] year
);
    import cal_pkg::*;

    logic [7:0] wday_q, mday_q, mon_q, yy_q, cent_q;
    logic       mday_wrap, mon_wrap, yy_wrap;

    assign mday_wrap = mday_q == month_last(mon_q, leap_year(cent_q, yy_q));
    assign mon_wrap  = mon_q  == 8'h12;
    assign yy_wrap   = yy_q   == 8'h99;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wday_q <= 8'h00;
            mday_q <= 8'h01;
            mon_q  <= 8'h01;
            yy_q   <= 8'h00;
            cent_q <= 8'h20;
        end else begin
            if (wr_wday)
                wday_q <= wdata[7:0];
            else if (tick)
                wday_q <= (wday_q == 8'h06) ? 8'h00 : bcd_next(wday_q);

            if (wr_mday)
                mday_q <= wdata[7:0];
            else if (tick)
                mday_q <= mday_wrap ? 8'h01 : bcd_next(mday_q);

            if (wr_mon)
                mon_q <= wdata[7:0];
            else if (tick && mday_wrap)
                mon_q <= mon_wrap ? 8'h01 : bcd_next(mon_q);

            if (wr_yr_lo)
                yy_q <= wdata[7:0];
            else if (tick && mday_wrap && mon_wrap)
                yy_q <= yy_wrap ? 8'h00 : bcd_next(yy_q);

            if (wr_yr_hi)
                cent_q <= wdata[15:8];
            else if (tick && mday_wrap && mon_wrap && yy_wrap)
                cent_q <= (cent_q == 8'h99) ? 8'h00 : bcd_next(cent_q);
        end
    end

    assign wday = wday_q;
    assign mday = mday_q;
    assign mon  = mon_q;
    assign year = {cent_q, yy_q};

    // R5: weekday wraps from 6 to 0
    a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !wr_wday && wday_q == 8'h06) |-> wday_q == 8'h00);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
    parameter int unsigned PRE_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        bus_we,
    input  logic        bus_wide,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        carry_irq
);
    import cal_pkg::*;

    localparam int unsigned SUB_W = 7;

    run_state_e state_q, state_d;
    logic       run, en;
    logic       flag_q, ie_q;
    logic       wr_stat, wr_ctrl, presc_clr, sec_tick, day_tick;
    logic [SUB_W-1:0] sub;
    logic [7:0] sec, min, hour, wday, mday, mon;
    logic [15:0] year;

    assign wr_stat   = bus_we && bus_addr == A_STAT;
    assign wr_ctrl   = bus_we && bus_addr == A_CTRL;
    assign presc_clr = wr_ctrl && bus_wdata[1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state: a run-control write selects OFF, HALT or RUN
    always_comb begin
        state_d = state_q;
        if (wr_ctrl) begin
            if (!bus_wdata[2])     state_d = ST_OFF;
            else if (bus_wdata[0]) state_d = ST_RUN;
            else                   state_d = ST_HALT;
        end
    end

    // Outputs of the state machine
    always_comb begin
        run = 1'b0;
        en  = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_HALT: en = 1'b1;
            ST_RUN:  begin en = 1'b1; run = 1'b1; end
            default: ;
        endcase
    end

    // Status: sticky carry flag and its interrupt enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (sec_tick)                     flag_q <= 1'b1;
            else if (wr_stat && !bus_wdata[0]) flag_q <= 1'b0;
            if (wr_stat) ie_q <= bus_wdata[1];
        end
    end

    assign carry_irq = flag_q && ie_q;

    cal_prescaler #(.PRE_DIV(PRE_DIV), .SUB_W(SUB_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(presc_clr),
        .ref_tick(ref_tick), .sub(sub), .sec_tick(sec_tick)
    );

    cal_hms u_hms (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .wr_sec (bus_we && bus_addr == A_SEC),
        .wr_min (bus_we && bus_addr == A_MIN),
        .wr_hour(bus_we && bus_addr == A_HOUR),
        .wdata(bus_wdata[7:0]),
        .sec(sec), .min(min), .hour(hour), .day_tick(day_tick)
    );

    cal_date u_date (
        .clk(clk), .rst_n(rst_n), .tick(day_tick),
        .wr_wday (bus_we && bus_addr == A_WDAY),
        .wr_mday (bus_we && bus_addr == A_MDAY),
        .wr_mon  (bus_we && bus_addr == A_MON),
        .wr_yr_lo(bus_we && bus_addr == A_YEAR),
        .wr_yr_hi(bus_we && bus_wide && bus_addr == A_YEAR),
        .wdata(bus_wdata),
        .wday(wday), .mday(mday), .mon(mon), .year(year)
    );

    // Read mux
    always_comb begin
        bus_rdata = 16'h0000;
        case (bus_addr)
            A_SUB:   bus_rdata = {{(16-SUB_W){1'b0}}, sub};
            A_SEC:   bus_rdata = {8'h00, sec};
            A_MIN:   bus_rdata = {8'h00, min};
            A_HOUR:  bus_rdata = {8'h00, hour};
            A_WDAY:  bus_rdata = {8'h00, wday};
            A_MDAY:  bus_rdata = {8'h00, mday};
            A_MON:   bus_rdata = {8'h00, mon};
            A_YEAR:  bus_rdata = year;
            A_STAT:  bus_rdata = {14'h0000, ie_q, flag_q};
            A_CTRL:  bus_rdata = {13'h0000, en, 1'b0, run};
            default: bus_rdata = 16'h0000;
        endcase
    end

    // R9: the carry flag stays set until a clearing write
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(wr_stat && !bus_wdata[0]) |=> flag_q);
    // R11: outside RUN the sub-second count is frozen
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) && !presc_clr |=> $stable(sub));
    // R11: no seconds step outside RUN
    a_r11_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !sec_tick);
endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_wide = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        carry_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_calendar #(.PRE_DIV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_we(bus_we), .bus_wide(bus_wide), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .carry_irq(carry_irq)
    );

    // Each entry packs {year16, month, day, weekday, hour, min, sec}.
    // Left half: start value. Right half: value one second later.
    localparam logic [127:0] VEC [14] = '{
        {64'h2024_03_15_03_10_20_30, 64'h2024_03_15_03_10_20_31}, // R3
        {64'h2024_03_15_03_10_20_59, 64'h2024_03_15_03_10_21_00}, // R4
        {64'h2024_03_15_03_10_59_59, 64'h2024_03_15_03_11_00_00}, // R4
        {64'h2024_03_15_06_23_59_59, 64'h2024_03_16_00_00_00_00}, // R4 R5
        {64'h2024_04_30_02_23_59_59, 64'h2024_05_01_03_00_00_00}, // R6
        {64'h2024_01_31_03_23_59_59, 64'h2024_02_01_04_00_00_00}, // R6
        {64'h2023_02_28_02_23_59_59, 64'h2023_03_01_03_00_00_00}, // R7
        {64'h2024_02_28_03_23_59_59, 64'h2024_02_29_04_00_00_00}, // R7
        {64'h2024_02_29_04_23_59_59, 64'h2024_03_01_05_00_00_00}, // R7
        {64'h2100_02_28_00_23_59_59, 64'h2100_03_01_01_00_00_00}, // R7
        {64'h2000_02_28_01_23_59_59, 64'h2000_02_29_02_00_00_00}, // R7
        {64'h2024_12_31_02_23_59_59, 64'h2025_01_01_03_00_00_00}, // R6
        {64'h2099_12_31_03_23_59_59, 64'h2100_01_01_04_00_00_00}, // R8
        {64'h9999_12_31_05_23_59_59, 64'h0000_01_01_06_00_00_00}  // R8
    };

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic wide);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_all(output logic [63:0] v);
        logic [15:0] d;
        rd(4'd7, d); v[63:48] = d;
        rd(4'd6, d); v[47:40] = d[7:0];
        rd(4'd5, d); v[39:32] = d[7:0];
        rd(4'd4, d); v[31:24] = d[7:0];
        rd(4'd3, d); v[23:16] = d[7:0];
        rd(4'd2, d); v[15:8]  = d[7:0];
        rd(4'd1, d); v[7:0]   = d[7:0];
    endtask

    task automatic load_all(input logic [63:0] v);
        wr(4'd7, v[63:48], 1'b1);
        wr(4'd6, {8'h00, v[47:40]}, 1'b0);
        wr(4'd5, {8'h00, v[39:32]}, 1'b0);
        wr(4'd4, {8'h00, v[31:24]}, 1'b0);
        wr(4'd3, {8'h00, v[23:16]}, 1'b0);
        wr(4'd2, {8'h00, v[15:8]}, 1'b0);
        wr(4'd1, {8'h00, v[7:0]}, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [63:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        rd_all(v);
        chk("R1 fields", v, 64'h2000_01_01_00_00_00_00);
        rd(4'd9, d); chk("R1 ctrl", 64'(d), 64'h0);
        rd(4'd8, d); chk("R1 status", 64'(d), 64'h0);
        chk("R1 irq", 64'(carry_irq), 64'h0);

        // R11: OFF does not count
        ticks(300);
        rd(4'd0, d); chk("R11 off frozen sub", 64'(d), 64'h0);

        // R2: sub-second steps every PRE_DIV ticks
        wr(4'd9, 16'h0006, 1'b0);
        wr(4'd9, 16'h0005, 1'b0);
        rd(4'd9, d); chk("R11 ctrl run readback", 64'(d), 64'h5);
        ticks(10);
        rd(4'd0, d); chk("R2 sub after 10 ticks", 64'(d), 64'h5);

        // R11: HALT freezes
        wr(4'd9, 16'h0004, 1'b0);
        rd(4'd9, d); chk("R11 ctrl halt readback", 64'(d), 64'h4);
        ticks(20);
        rd(4'd0, d); chk("R11 halt frozen sub", 64'(d), 64'h5);

        // R12: prescaler clear
        wr(4'd9, 16'h0006, 1'b0);
        rd(4'd0, d); chk("R12 sub cleared", 64'(d), 64'h0);
        rd(4'd9, d); chk("R12 clear bit reads 0", 64'(d), 64'h4);

        // R11: enable 0 with run 1 stays OFF
        wr(4'd9, 16'h0001, 1'b0);
        rd(4'd9, d); chk("R11 enable low readback", 64'(d), 64'h0);

        // R3: second lands on tick 256, not 255
        wr(4'd9, 16'h0006, 1'b0);
        wr(4'd1, 16'h0010, 1'b0);
        wr(4'd8, 16'h0000, 1'b0);
        wr(4'd9, 16'h0005, 1'b0);
        ticks(255);
        rd(4'd1, d); chk("R3 no step at 255", 64'(d), 64'h10);
        rd(4'd8, d); chk("R9 flag clear before step", 64'(d), 64'h0);
        ticks(1);
        rd(4'd1, d); chk("R3 step at 256", 64'(d), 64'h11);
        rd(4'd0, d); chk("R3 sub wrapped", 64'(d), 64'h0);

        // Vector table: R4 R5 R6 R7 R8
        for (int i = 0; i < 14; i++) begin
            wr(4'd9, 16'h0004, 1'b0);
            load_all(VEC[i][127:64]);
            wr(4'd9, 16'h0006, 1'b0);
            wr(4'd8, 16'h0000, 1'b0);
            wr(4'd9, 16'h0005, 1'b0);
            ticks(256);
            wr(4'd9, 16'h0004, 1'b0);
            rd_all(v);
            chk($sformatf("R6 R7 R8 vector %0d", i), v, VEC[i][63:0]);
            rd(4'd8, d); chk($sformatf("R9 flag set vector %0d", i), 64'(d), 64'h1);
        end

        // R10 / R9: interrupt and sticky flag
        chk("R10 irq off while disabled", 64'(carry_irq), 64'h0);
        wr(4'd8, 16'h0003, 1'b0);
        chk("R10 irq on", 64'(carry_irq), 64'h1);
        rd(4'd8, d); chk("R9 write 1 keeps flag", 64'(d), 64'h3);
        wr(4'd8, 16'h0002, 1'b0);
        rd(4'd8, d); chk("R9 write 0 clears flag", 64'(d), 64'h2);
        chk("R10 irq off after clear", 64'(carry_irq), 64'h0);
        wr(4'd8, 16'h0000, 1'b0);

        // R13: wide and narrow year writes, field load
        wr(4'd7, 16'h1234, 1'b1);
        rd(4'd7, d); chk("R13 wide year", 64'(d), 64'h1234);
        wr(4'd7, 16'hAB56, 1'b0);
        rd(4'd7, d); chk("R13 narrow year low only", 64'(d), 64'h1256);
        wr(4'd2, 16'h0042, 1'b0);
        rd(4'd2, d); chk("R13 minute load", 64'(d), 64'h42);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule